// File: doc/BRIEF.md
# Fetch pipeline controller

This block runs the front of a small in-order processor as three stages: fetch, decode and execute. It reads aligned 32-bit words from an instruction memory and cuts them into instructions. An instruction is either one halfword or two halfwords long, so a single word can carry two short instructions. It also lets a long instruction start in the upper half of one word and end in the lower half of the next. A new instruction moves into decode each cycle, and the instruction already in decode moves on to execute. The decoding and execution logic sit outside the block. Only the two stage registers and their contents are shown at the pins.

The execute side controls the pipeline through two plain inputs. A stall input freezes both stage registers while execute is busy with a multi-cycle operation. A branch-taken input, given with a target address, empties decode and the internal word buffer and restarts fetching at the target. The target may point at the upper half of a word. The memory interface uses a valid/ready request channel. The read response has no ready signal, because the block only issues a request when it has already reserved a buffer slot for the returned word.

Top module: `fetch_pipe_ctrl`

## Requirements
- R1: During reset and after its release, `dec_valid` and `exe_valid` stay 0 until the first instruction arrives. The first request address is `RESET_PC` with its two low bits cleared (default 0).
- R2: Every request address is a multiple of 4, and each accepted request is followed by one 4 bytes higher. While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` does not change, unless a branch is taken. Buffered words plus accepted requests still awaiting a response never exceed `DEPTH`.
- R3: The memory returns exactly one response per accepted request, in order, at least one cycle after acceptance. The block takes every response. Responses to requests accepted up to and including the cycle of a taken branch are thrown away.
- R4: The low halfword of a word (bits 15:0) is used before its high halfword. Every instruction reaches execute exactly once and in program order, and `exe_pc` holds its byte address. An instruction moves from decode to execute on each cycle where `exe_stall` is low.
- R5: A first halfword whose bits 15:13 are 111 and whose bits 12:11 are not 00 starts a 32-bit instruction. Such an instruction is shown as {first, second} with `is32` = 1, and its second halfword may come from the next word. Any other halfword is a 16-bit instruction, shown as {16'h0000, halfword} with `is32` = 0.
- R6: Take the case where responses arrive the cycle after acceptance, `req_ready` is held high, there is no stall and the code is all 16-bit. After the start-up cycles, `exe_valid` is high on every cycle.
- R7: In the cycle after `exe_stall` is high with no branch, all decode and execute outputs hold their values.
- R8: In the cycle after `br_taken` is high, `dec_valid` and `exe_valid` are 0. The next instruction to reach execute is the one at the target.
- R9: If the target has address bit 1 set, the low half of the first fetched word is skipped. The first instruction issued starts at the upper halfword.
- R10: When `br_taken` and `exe_stall` are high in the same cycle, the branch wins: both stages are emptied and fetching restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Word-aligned fetch byte address |
| rsp_valid | input | 1 | Read data valid, always accepted |
| rsp_data | input | 32 | Read data word |
| exe_stall | input | 1 | Execute is busy; hold both stages |
| br_taken | input | 1 | Branch taken; flush and redirect |
| br_target | input | 31 | Branch target as a halfword address (byte address bits 31:1) |
| dec_valid | output | 1 | Decode stage holds an instruction |
| dec_is32 | output | 1 | Decode instruction is 32-bit |
| dec_pc | output | 32 | Decode instruction byte address |
| dec_instr | output | 32 | Decode instruction bits |
| exe_valid | output | 1 | Execute stage holds an instruction |
| exe_is32 | output | 1 | Execute instruction is 32-bit |
| exe_pc | output | 32 | Execute instruction byte address |
| exe_instr | output | 32 | Execute instruction bits |

## Verification
The assertions check the following on every cycle:
- The request channel stays aligned and stable under back-pressure.
- The word buffer never overflows and the discard count never exceeds the outstanding requests.
- Stalls freeze both stages and flushes leave bubbles.

Only the bench scenarios can show the rest:
- The instruction stream reaching execute matches the program.
- Long instructions split across words are stitched together correctly.
- Odd-halfword targets skip the right half.
- Stale responses after a flush never appear.
- Full throughput is reached on short code.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned ADDR_W = 32;

  typedef struct packed {
    logic              valid;
    logic              is32;
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] instr;
  } slot_t;

  // A halfword opens a two-halfword instruction when its top five bits are 111xx with xx != 00
  function automatic logic hw_is_wide(input logic [HALF_W-1:0] hw);
    return (hw[15:13] == 3'b111) && (hw[12:11] != 2'b00);
  endfunction
endpackage

// File: rtl/fpc_prefetch.sv
module fpc_prefetch import fpc_pkg::*; #(
  parameter int unsigned       DEPTH    = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int unsigned      PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned      CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-3:0] flush_word,
  input  logic              pop,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic [CW-1:0]     cnt,
  output logic [WORD_W-1:0] head_word,
  output logic [HALF_W-1:0] next_lo
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     rd_ptr, wr_ptr;
  logic [CW-1:0]     cnt_q, out_q, drop_q, out_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [CW:0]       in_use;
  logic              fire, accept;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Credit: a slot is reserved for every request still in flight
  assign in_use    = {1'b0, cnt_q} + {1'b0, out_q};
  assign req_valid = in_use < (CW+1)'(DEPTH);
  assign req_addr  = addr_q;
  assign fire      = req_valid && req_ready;
  assign accept    = rsp_valid && (drop_q == '0);
  assign out_nx    = out_q + CW'(fire) - CW'(rsp_valid);
  assign cnt       = cnt_q;
  assign head_word = mem[rd_ptr];
  assign next_lo   = mem[wrap_inc(rd_ptr)][HALF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
      out_q  <= '0;
      drop_q <= '0;
      addr_q <= {RESET_PC[ADDR_W-1:2], 2'b00};
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      out_q <= out_nx;
      if (flush) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
        cnt_q  <= '0;
        drop_q <= out_nx;
        addr_q <= {flush_word, 2'b00};
      end else begin
        if (fire) addr_q <= addr_q + ADDR_W'(4);
        if (rsp_valid && (drop_q != '0)) drop_q <= drop_q - 1'b1;
        if (accept) begin
          mem[wr_ptr] <= rsp_data;
          wr_ptr      <= wrap_inc(wr_ptr);
        end
        if (pop) rd_ptr <= wrap_inc(rd_ptr);
        cnt_q <= cnt_q + CW'(accept) - CW'(pop);
      end
    end
  end

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> (req_addr[1:0] == 2'b00)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_ready && !flush) |=> (req_valid && $stable(req_addr))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (accept && !pop && !flush) |-> (cnt_q < CW'(DEPTH))); // R3
  AST_DROP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) drop_q <= out_q); // R3
endmodule

// File: rtl/fpc_align.sv
module fpc_align import fpc_pkg::*; #(
  parameter int unsigned       DEPTH    = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int unsigned      CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-2:0] flush_half,
  input  logic              advance,
  input  logic [CW-1:0]     cnt,
  input  logic [WORD_W-1:0] head_word,
  input  logic [HALF_W-1:0] next_lo,
  output logic              pop,
  output slot_t             iss
);
  logic              hp_q;
  logic [ADDR_W-1:0] pc_q;
  logic [HALF_W-1:0] hw0, hw1;
  logic              wide, ok;
  logic [CW:0]       avail;
  logic [1:0]        sum;

  always_comb begin
    hw0   = hp_q ? head_word[WORD_W-1:HALF_W] : head_word[HALF_W-1:0];
    hw1   = hp_q ? next_lo : head_word[WORD_W-1:HALF_W];
    wide  = hw_is_wide(hw0);
    avail = (cnt == '0) ? '0 : ({cnt, 1'b0} - (CW+1)'(hp_q));
    ok    = advance && !flush && (avail != '0) && (!wide || (avail >= (CW+1)'(2)));
    sum   = {1'b0, hp_q} + (wide ? 2'd2 : 2'd1);
    pop   = ok && sum[1];
    iss.valid = ok;
    iss.is32  = wide;
    iss.pc    = pc_q;
    iss.instr = wide ? {hw0, hw1} : {{HALF_W{1'b0}}, hw0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_q <= RESET_PC[1];
      pc_q <= {RESET_PC[ADDR_W-1:1], 1'b0};
    end else if (flush) begin
      hp_q <= flush_half[0];
      pc_q <= {flush_half, 1'b0};
    end else if (ok) begin
      hp_q <= sum[0];
      pc_q <= pc_q + (wide ? ADDR_W'(4) : ADDR_W'(2));
    end
  end

  AST_ISSUE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n) iss.valid |-> (cnt != '0)); // R4
  AST_WIDE_WHOLE: assert property (@(posedge clk) disable iff (!rst_n) (iss.valid && iss.is32 && hp_q) |-> (cnt >= CW'(2))); // R5
endmodule

// File: rtl/fpc_stages.sv
module fpc_stages import fpc_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stall,
  input  logic  flush,
  input  slot_t iss,
  output slot_t dec,
  output slot_t exe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec <= '0;
      exe <= '0;
    end else if (flush) begin
      dec <= '0;
      exe <= '0;
    end else if (!stall) begin
      exe <= dec;
      dec <= iss;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (stall && !flush) |=> ($stable(dec) && $stable(exe))); // R7
  AST_FLUSH_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (!dec.valid && !exe.valid)); // R8
  AST_BRANCH_WINS: assert property (@(posedge clk) disable iff (!rst_n) (flush && stall) |=> !exe.valid); // R10
  AST_DEC_TO_EXE: assert property (@(posedge clk) disable iff (!rst_n) (!stall && !flush) |=> (exe == $past(dec))); // R4
endmodule

// File: rtl/fetch_pipe_ctrl.sv
module fetch_pipe_ctrl import fpc_pkg::*; #(
  parameter int unsigned       DEPTH    = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int unsigned      CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  input  logic              exe_stall,
  input  logic              br_taken,
  input  logic [ADDR_W-1:1] br_target,
  output logic              dec_valid,
  output logic              dec_is32,
  output logic [ADDR_W-1:0] dec_pc,
  output logic [WORD_W-1:0] dec_instr,
  output logic              exe_valid,
  output logic              exe_is32,
  output logic [ADDR_W-1:0] exe_pc,
  output logic [WORD_W-1:0] exe_instr
);
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] head_word;
  logic [HALF_W-1:0] next_lo;
  logic              pop;
  slot_t             iss, dec_s, exe_s;

  fpc_prefetch #(.DEPTH(DEPTH), .RESET_PC(RESET_PC)) u_prefetch (
    .clk(clk), .rst_n(rst_n), .flush(br_taken), .flush_word(br_target[ADDR_W-1:2]),
    .pop(pop), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cnt(cnt), .head_word(head_word),
    .next_lo(next_lo)
  );

  fpc_align #(.DEPTH(DEPTH), .RESET_PC(RESET_PC)) u_align (
    .clk(clk), .rst_n(rst_n), .flush(br_taken), .flush_half(br_target),
    .advance(!exe_stall), .cnt(cnt), .head_word(head_word), .next_lo(next_lo),
    .pop(pop), .iss(iss)
  );

  fpc_stages u_stages (
    .clk(clk), .rst_n(rst_n), .stall(exe_stall), .flush(br_taken),
    .iss(iss), .dec(dec_s), .exe(exe_s)
  );

  assign dec_valid = dec_s.valid;
  assign dec_is32  = dec_s.is32;
  assign dec_pc    = dec_s.pc;
  assign dec_instr = dec_s.instr;
  assign exe_valid = exe_s.valid;
  assign exe_is32  = exe_s.is32;
  assign exe_pc    = exe_s.pc;
  assign exe_instr = exe_s.instr;
endmodule

// File: tb/fetch_pipe_ctrl_bench.sv
`timescale 1ns/1ps
module fetch_pipe_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        exe_stall, br_taken;
  logic [31:1] br_target;
  logic        dec_valid, dec_is32, exe_valid, exe_is32;
  logic [31:0] dec_pc, dec_instr, exe_pc, exe_instr;

  always #2.5 clk = ~clk;

  fetch_pipe_ctrl #(.DEPTH(2), .RESET_PC(32'h0)) u_fetch_pipe_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .exe_stall(exe_stall), .br_taken(br_taken), .br_target(br_target),
    .dec_valid(dec_valid), .dec_is32(dec_is32), .dec_pc(dec_pc), .dec_instr(dec_instr),
    .exe_valid(exe_valid), .exe_is32(exe_is32), .exe_pc(exe_pc), .exe_instr(exe_instr)
  );

  int          checks = 0;
  int          errors = 0;
  int          mode = 0;
  int unsigned seed = 32'h1234_5678;
  logic [31:0] q_addr[$];
  int          q_due[$];

  function automatic int unsigned rnd100();
    seed = seed * 32'd1103515245 + 32'd12345;
    return (seed >> 16) % 100;
  endfunction

  // Program image: halfword at byte address a, content chosen by the scenario mode
  function automatic logic [15:0] prog(input logic [31:0] a);
    int unsigned h;
    h = a >> 1;
    case (mode)
      0:       prog = 16'h4000 | 16'(h % 4096);
      1:       prog = ((h % 3) == 1) ? (16'hF800 | 16'(h % 2048)) : (16'h4000 | 16'(h % 4096));
      default: prog = 16'hE800 | 16'(h % 2048);
    endcase
  endfunction

  function automatic bit is_wide(input logic [15:0] hw);
    return (hw[15:13] == 3'b111) && (hw[12:11] != 2'b00);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_scn(input int m, input int lat, input int rdy, input int stl,
                         input int brp, input int nret, input bit thru);
    int          ret, k, thr, tgt;
    bit          pstall, pbr, pwait, after_br, w;
    logic [31:0] paddr, mpc, einstr;
    logic [15:0] h0, h1;
    logic [129:0] snap, cur;
    string       tag;
    ret = 0; k = 0; thr = 0; pstall = 0; pbr = 0; pwait = 0; after_br = 0;
    paddr = '0; snap = '0;
    mode = m;
    rst_n = 1'b0; exe_stall = 1'b0; br_taken = 1'b0; br_target = '0;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    q_addr.delete(); q_due.delete();
    repeat (3) @(negedge clk);
    chk(!dec_valid && !exe_valid, "R1 stages empty in reset", 64'({dec_valid, exe_valid}), 64'(0));
    chk(req_addr == 32'h0, "R1 first request address", 64'(req_addr), 64'(0));
    rst_n = 1'b1;
    mpc = 32'h0;
    while (ret < nret && k < 4000) begin
      @(negedge clk);
      k++;
      cur = {dec_valid, dec_is32, dec_pc, dec_instr, exe_valid, exe_is32, exe_pc, exe_instr};
      if (pbr) begin
        if (pstall) chk(!dec_valid && !exe_valid, "R10 branch beats stall", 64'({dec_valid, exe_valid}), 64'(0));
        else        chk(!dec_valid && !exe_valid, "R8 flush bubble", 64'({dec_valid, exe_valid}), 64'(0));
      end else if (pstall) begin
        chk(cur == snap, "R7 stall hold", 64'(cur), 64'(snap));
      end
      if (req_valid) chk(req_addr[1:0] == 2'b00, "R2 aligned request", 64'(req_addr), 64'(req_addr & 32'hFFFF_FFFC));
      if (pwait && !pbr) chk(req_valid && (req_addr == paddr), "R2 request held", 64'({req_valid, req_addr}), 64'({1'b1, paddr}));
      // memory response, in order, at its due cycle
      if (q_addr.size() > 0 && q_due[0] <= k) begin
        rsp_valid = 1'b1;
        rsp_data  = {prog(q_addr[0] + 32'd2), prog(q_addr[0])};
        void'(q_addr.pop_front());
        void'(q_due.pop_front());
      end else begin
        rsp_valid = 1'b0;
        rsp_data  = '0;
      end
      exe_stall = (rnd100() < stl);
      br_taken  = exe_valid && (rnd100() < brp);
      tgt       = int'(rnd100() % 64) * 2;
      br_target = 31'(tgt >> 1);
      req_ready = (rnd100() < rdy);
      if (req_valid && req_ready) begin
        q_addr.push_back(req_addr);
        q_due.push_back(k + lat);
      end
      pwait = req_valid && !req_ready;
      paddr = req_addr;
      if (thru && k >= 10 && k < 30 && exe_valid) thr++;
      if (exe_valid && (!exe_stall || br_taken)) begin
        h0 = prog(mpc);
        w  = is_wide(h0);
        h1 = prog(mpc + 32'd2);
        einstr = w ? {h0, h1} : {16'h0000, h0};
        if (after_br) begin
          if (mpc[1]) tag = "R9 R3 odd-halfword target";
          else        tag = "R8 R3 branch target";
        end else begin
          if (w) tag = "R5 wide instruction";
          else   tag = "R4 program order";
        end
        chk((exe_pc == mpc) && (exe_is32 == w) && (exe_instr == einstr), tag,
            {exe_pc, exe_instr}, {mpc, einstr});
        ret++;
        after_br = 0;
        mpc = mpc + (w ? 32'd4 : 32'd2);
        if (br_taken) begin
          mpc = 32'(tgt);
          after_br = 1;
        end
      end
      pstall = exe_stall;
      pbr    = br_taken;
      snap   = cur;
    end
    chk(ret >= nret, "R4 stream progress", 64'(ret), 64'(nret));
    if (thru) chk(thr == 20, "R6 one per cycle", 64'(thr), 64'(20));
  endtask

  initial begin
    run_scn(0, 1, 100, 0, 0, 60, 1'b1);
    run_scn(1, 2, 70, 25, 0, 60, 1'b0);
    run_scn(2, 1, 100, 20, 12, 80, 1'b0);
    run_scn(1, 3, 50, 30, 15, 80, 1'b0);
    run_scn(0, 2, 80, 10, 20, 80, 1'b0);
    run_scn(2, 3, 60, 35, 25, 80, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog actual hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule